// File: doc/BRIEF.md
# Sixteen-Pin Multi-Mode I/O Port

This block is one general-purpose I/O port of up to sixteen pins behind a simple synchronous register interface. Every pin carries a two-bit drive mode: high-impedance input, push-pull output, open-drain, or quasi-bidirectional. In quasi mode a 0 pulls the pad low hard, and a 1 lets go of the pad and asks the pad ring for its weak pull-up. The port holds an output-data register, a per-pin write-protect mask for that register, a gate that turns off each pin's digital input path, and a read-only view of the synchronized pad levels.

Software may update the whole port at once, or one pin at a time through an alias window. The window gives each pin its own word. A read of a pin's word returns that pin's input level in bit 0. A write to it sets that pin's output bit from bit 0 of the data. The protect mask applies only to whole-port writes. Pad inputs pass through a two-flop synchronizer before they reach the input view. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every pin is in input mode (pad_oe, pad_out and pad_pullup all 0), and the output-data, mask, mode and input-disable registers read 0.
- R2: The mode register at byte offset 0x0C gives pin n the field at bits 2n+1:2n. Code 0 releases the pad (oe 0, out 0). Code 1 drives the pad push-pull (oe 1, out equal to the pin's output bit).
- R3: Code 2 (open-drain) enables the driver only while the output bit is 0, always drives a 0, and never requests the pull-up.
- R4: Code 3 (quasi-bidirectional) enables the driver only while the output bit is 0, always drives a 0, and requests the pull-up exactly when the output bit is 1.
- R5: The output-data register at offset 0x00 (pin n at bit n) reads back what was written, except that a whole-port write leaves unchanged every bit whose mask bit is 1.
- R6: The mask register at offset 0x04 (pin n at bit n) is readable and writable.
- R7: The input register at offset 0x08 (pin n at bit n) returns pad levels through two synchronizer flops. A read strobe on the first or second rising edge after a pad change returns the old level, and a strobe on the third edge returns the new level.
- R8: The input-disable register at offset 0x10 holds pin n at bit n+16 and reads 0 in bits 15:0. A disabled pin reads as 0 in both the input register and its alias.
- R9: The alias word for pin n is at byte offset 0x40 + 4n. A read returns the pin's input level in bit 0 with all other bits 0. A write sets the pin's output bit to data bit 0, regardless of the mask.
- R10: A read of any unmapped offset returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_addr | input | 8 | Byte offset in the port's register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held until the next read |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Value driven onto each pad |
| pad_oe | output | NUM_PINS | Output-driver enable for each pad |
| pad_pullup | output | NUM_PINS | Weak pull-up request for each pad |

## Verification
On every cycle, the assertions check that each pin's pad signals agree with its current mode code and output bit in all four modes. They also check that a whole-port write never alters a protected bit, that a disabled pin never shows a 1 in an input read, and that reset leaves the pads released. The bench scenarios are the only place that shows the synchronizer's exact read latency, the alias window writing past the mask, and the alias reads of single pins. They also cover the input-disable field's position in the upper half of its word and the silence of unmapped offsets.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the multi-mode I/O port.
// Assumes a byte-addressed register space of 256 bytes with 32-bit words.
package gpio_port_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int MAX_PIN = 16;
    localparam int DIS_LSB = 16;   // input-disable field starts here

    localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IN    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_INDIS = 8'h10;

    // Alias window occupies 0x40..0x7F: addr[7:6] == 2'b01
    localparam logic [1:0] ALIAS_TAG = 2'b01;

    typedef enum logic [1:0] {
        PM_INPUT = 2'd0,
        PM_PUSH  = 2'd1,
        PM_OPEN  = 2'd2,
        PM_QUASI = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pad input levels.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pin_drive.sv
// Module: per-pin pad control decode from the mode code and the output bit.
// Assumes the pad ring provides the weak pull-up; this only requests it.
module gpio_pin_drive
    import gpio_port_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       out_bit,
    output logic       pad_drv,
    output logic       pad_en,
    output logic       pull_req
);

    pin_mode_e mode_e;
    assign mode_e = pin_mode_e'(mode);

    // Translate the mode and output bit into pad controls.
    always_comb begin
        pad_drv  = 1'b0;
        pad_en   = 1'b0;
        pull_req = 1'b0;
        case (mode_e)
            PM_INPUT: begin
                pad_en = 1'b0;
            end
            PM_PUSH: begin
                pad_en  = 1'b1;
                pad_drv = out_bit;
            end
            PM_OPEN: begin
                pad_en = ~out_bit;
            end
            PM_QUASI: begin
                pad_en   = ~out_bit;
                pull_req = out_bit;
            end
            default: begin
                pad_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_port_regfile.sv
// Module: register storage, write decode and registered read mux of the port.
// Assumes at most one of bus_wr / bus_rd per cycle; the low two address
// bits are ignored inside the alias window.
module gpio_port_regfile
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_level,
    output logic [2*NUM_PINS-1:0] mode_o,
    output logic [NUM_PINS-1:0]   dout_o,
    output logic [NUM_PINS-1:0]   mask_o,
    output logic [NUM_PINS-1:0]   indis_o
);

    localparam int MODE_W = 2 * NUM_PINS;
    localparam int IDX_W  = $clog2(MAX_PIN);

    logic [MODE_W-1:0]   mode_q;
    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] indis_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [DATA_W-1:0]   rd_next;
    logic [NUM_PINS-1:0] in_view;
    logic [IDX_W-1:0]    alias_idx;
    logic                alias_ok;

    // Decode whether the address falls on an implemented pin alias.
    always_comb begin
        alias_idx = bus_addr[IDX_W+1:2];
        alias_ok  = (bus_addr[ADDR_W-1:ADDR_W-2] == ALIAS_TAG) &&
                    (int'(alias_idx) < NUM_PINS);
    end

    // Gate the synchronized levels by the input-disable bits.
    assign in_view = pin_level & ~indis_q;

    // Register writes: whole-port output honours the mask, aliases do not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dout_q  <= '0;
            mask_q  <= '0;
            indis_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_OUT:   dout_q  <= (dout_q & mask_q) |
                                      (bus_wdata[NUM_PINS-1:0] & ~mask_q);
                OFS_MASK:  mask_q  <= bus_wdata[NUM_PINS-1:0];
                OFS_MODE:  mode_q  <= bus_wdata[MODE_W-1:0];
                OFS_INDIS: indis_q <= bus_wdata[DIS_LSB +: NUM_PINS];
                default: begin
                    if (alias_ok) begin
                        for (int i = 0; i < NUM_PINS; i++) begin
                            if (int'(alias_idx) == i) dout_q[i] <= bus_wdata[0];
                        end
                    end
                end
            endcase
        end
    end

    // Select the word a read at the current address returns.
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            OFS_OUT:   rd_next[NUM_PINS-1:0]          = dout_q;
            OFS_MASK:  rd_next[NUM_PINS-1:0]          = mask_q;
            OFS_IN:    rd_next[NUM_PINS-1:0]          = in_view;
            OFS_MODE:  rd_next[MODE_W-1:0]            = mode_q;
            OFS_INDIS: rd_next[DIS_LSB +: NUM_PINS]   = indis_q;
            default: begin
                if (alias_ok) begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        if (int'(alias_idx) == i) rd_next[0] = in_view[i];
                    end
                end
            end
        endcase
    end

    // Capture read data on the read strobe and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;
    assign mode_o    = mode_q;
    assign dout_o    = dout_q;
    assign mask_o    = mask_q;
    assign indis_o   = indis_q;

endmodule

// File: rtl/gpio_port_regs.sv
// Module: top of the multi-mode I/O port; joins synchronizer, register file
// and one pad-control decoder per pin.
// Assumes NUM_PINS between 1 and 16 and a single clock domain for the bus.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pullup
);

    logic [NUM_PINS-1:0]   pin_level;
    logic [2*NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0]   dout_q;
    logic [NUM_PINS-1:0]   mask_q;
    logic [NUM_PINS-1:0]   indis_q;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_level)
    );

    gpio_port_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (pin_level),
        .mode_o    (mode_q),
        .dout_o    (dout_q),
        .mask_o    (mask_q),
        .indis_o   (indis_q)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gpio_pin_drive u_drive (
            .mode     (mode_q[2*g +: 2]),
            .out_bit  (dout_q[g]),
            .pad_drv  (pad_out[g]),
            .pad_en   (pad_oe[g]),
            .pull_req (pad_pullup[g])
        );
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Checker: properties over the port's pad controls and register updates.
// Assumes it is bound into gpio_port_regs with its internal register wires.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic [NUM_PINS-1:0]   dout_q,
    input logic [NUM_PINS-1:0]   mask_q,
    input logic [NUM_PINS-1:0]   indis_q,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_pullup
);

    // R1: first cycle out of reset leaves the pads released and registers clear
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && pad_pullup == '0 &&
                           dout_q == '0 && mode_q == '0));

    // R5: a whole-port write never moves a protected bit
    a_r5_mask_protects: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT) |=>
            (((dout_q ^ $past(dout_q)) & $past(mask_q)) == '0));

    // R8: a disabled pin never reads as 1 in the input register
    a_r8_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_IN) |=>
            ((bus_rdata[NUM_PINS-1:0] & $past(indis_q)) == '0));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        // R2: input code releases the pad
        a_r2_input_released: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*g +: 2] == 2'd0) |->
                (!pad_oe[g] && !pad_out[g] && !pad_pullup[g]));
        // R2: push-pull code drives the output bit
        a_r2_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*g +: 2] == 2'd1) |->
                (pad_oe[g] && pad_out[g] == dout_q[g] && !pad_pullup[g]));
        // R3: open-drain never drives high and never pulls up
        a_r3_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*g +: 2] == 2'd2) |->
                (!pad_out[g] && !pad_pullup[g] && (pad_oe[g] != dout_q[g])));
        // R4: quasi mode pulls up only while released
        a_r4_quasi: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*g +: 2] == 2'd3) |->
                (!pad_out[g] && (pad_oe[g] != pad_pullup[g]) &&
                 (pad_pullup[g] == dout_q[g])));
    end

endmodule

bind gpio_port_regs gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .mode_q     (mode_q),
    .dout_q     (dout_q),
    .mask_q     (mask_q),
    .indis_q    (indis_q),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pullup (pad_pullup)
);

// File: tb/gpio_port_regs_test.sv
// Bench: scoreboard of expected read words plus direct pad-control checks.
module gpio_port_regs_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  NP         = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_pullup;

    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic        rd_d   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    gpio_port_regs #(.NUM_PINS(NP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pullup (pad_pullup)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Remember that a read strobe was taken at this edge.
    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: compare each returned word against the queued expectation.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pads(input logic [NP-1:0] e_oe, input logic [NP-1:0] e_out,
                        input logic [NP-1:0] e_pu, input string t);
        n_vec++;
        if (pad_oe !== e_oe || pad_out !== e_out || pad_pullup !== e_pu) begin
            n_fail++;
            $display("FAIL %s: oe/out/pu=%h/%h/%h expected=%h/%h/%h",
                     t, pad_oe, pad_out, pad_pullup, e_oe, e_out, e_pu);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        pads('0, '0, '0, "R1 pads after reset");
        rd(8'h00, 32'h0, "R1 output register");
        rd(8'h04, 32'h0, "R1 mask register");
        rd(8'h0C, 32'h0, "R1 mode register");
        rd(8'h10, 32'h0, "R1 input-disable register");

        // R7: synchronized input levels and their latency
        pad_in = 16'hA5C3;
        idle(3);
        rd(8'h08, 32'h0000A5C3, "R7 input levels");
        pad_in = 16'h0F0F;
        rd(8'h08, 32'h0000A5C3, "R7 first edge old");
        rd(8'h08, 32'h0000A5C3, "R7 second edge old");
        rd(8'h08, 32'h00000F0F, "R7 third edge new");

        // R2 R3 R4: pin0 push-pull, pin1 open-drain, pin2 quasi, pin3 input
        wr(8'h0C, 32'h0000_0039);
        wr(8'h00, 32'h0000_0007);
        pads(16'h0001, 16'h0001, 16'h0004, "R2 R3 R4 output bits high");
        rd(8'h0C, 32'h0000_0039, "R2 mode readback");
        wr(8'h00, 32'h0000_0000);
        pads(16'h0007, 16'h0000, 16'h0000, "R2 R3 R4 output bits low");

        // R6 R5: mask protects the low byte on whole-port writes
        wr(8'h04, 32'h0000_00FF);
        rd(8'h04, 32'h0000_00FF, "R6 mask readback");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_FF00, "R5 masked whole-port write");

        // R9: alias writes bypass the mask
        wr(8'h4C, 32'h0000_0001);
        rd(8'h00, 32'h0000_FF08, "R9 alias write pin3 past mask");
        wr(8'h7C, 32'h0000_0002);
        rd(8'h00, 32'h0000_7F08, "R9 alias write pin15 uses bit0");

        // R2: all pins push-pull follow the output register
        wr(8'h0C, 32'h5555_5555);
        pads(16'hFFFF, 16'h7F08, 16'h0000, "R2 all push-pull");

        // R8: input disable in the upper half word
        pad_in = 16'hFFFF;
        idle(3);
        wr(8'h10, 32'h00F0_FFFF);
        rd(8'h10, 32'h00F0_0000, "R8 disable field position");
        rd(8'h08, 32'h0000_FF0F, "R8 disabled pins read zero");
        rd(8'h54, 32'h0000_0000, "R8 R9 alias read disabled pin5");
        rd(8'h60, 32'h0000_0001, "R9 alias read pin8 high");
        pad_in = 16'h0000;
        idle(3);
        rd(8'h60, 32'h0000_0000, "R9 alias read pin8 low");

        // R10: unmapped offsets
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0000_0000, "R10 unmapped read");
        rd(8'h00, 32'h0000_7F08, "R10 output untouched");
        rd(8'h04, 32'h0000_00FF, "R10 mask untouched");

        idle(2);
        finish_run();
    end

endmodule